// File: doc/BRIEF.md
# Eight-Code 32-bit Arithmetic Logic Unit

This block is a purely combinational arithmetic logic unit. It sits between operand registers and a result register in a simple processor datapath. It takes two 32-bit operands and a 3-bit operation code. It returns a 32-bit result and a flag that marks an all-zero result. The flag lets the surrounding control decide equality-based branches, by subtracting the two operands and testing the flag.

The unit provides three bitwise operations (AND, OR, XOR), addition and subtraction that wrap modulo 2^32, and logical shifts of the first operand by exactly one bit in either direction. It has no overflow or carry output, and shifts never take an amount. The one code left unused yields a defined all-zero result.

The block holds no state, so it has neither a clock nor a reset. Its outputs follow its inputs within the same cycle.

Top module: `alu32_core`

## Requirements
- R1: Code 000 gives `res_c = op_a & op_b`.
- R2: Code 001 gives `res_c = op_a | op_b`.
- R3: Code 011 gives `res_c = op_a ^ op_b`.
- R4: Code 010 gives `res_c = (op_a + op_b) mod 2^32`, and a carry out of bit 31 is dropped.
- R5: Code 110 gives `res_c = (op_a - op_b) mod 2^32`, computed as op_a plus the inverted op_b plus one. Equal operands therefore give 0.
- R6: Code 101 gives op_a shifted left by one, with bit 0 filled with 0. op_b has no effect on the result.
- R7: Code 111 gives op_a shifted right by one, with bit 31 filled with 0. op_b has no effect on the result.
- R8: Code 100 (unused) drives `res_c` to 0 and therefore asserts `res_zero`, whatever the operands are.
- R9: `res_zero` is 1 exactly when all 32 bits of `res_c` are 0, for every code.
- R10: The block holds no state. Both outputs reflect the present inputs within the same cycle the inputs are applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First operand; also the shift source |
| op_b | input | 32 | Second operand; not used by the shifts |
| op_sel | input | 3 | Operation code |
| res_c | output | 32 | Operation result |
| res_zero | output | 1 | High when res_c is all zeros |

## Verification
Every result of this unit is due in the same cycle that its operands and code are applied, because no register lies on any path. The bench changes the inputs just after a rising clock edge and samples both outputs at the following falling edge. That gives half a period for the logic to settle, and no check depends on the order of events at a clock edge. Every code is swept with directed corner operands and with a few thousand random pairs. The expected values are formed arithmetically in the bench: sums, differences, and doubling or halving for the shifts.

// File: rtl/alu32_pkg.sv
package alu32_pkg;
  localparam int unsigned OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_AND = 3'b000,
    OP_OR  = 3'b001,
    OP_ADD = 3'b010,
    OP_XOR = 3'b011,
    OP_RSV = 3'b100,
    OP_SLL = 3'b101,
    OP_SUB = 3'b110,
    OP_SRL = 3'b111
  } alu_op_e;
endpackage

// File: rtl/alu32_addsub.sv
module alu32_addsub #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o
);
  logic [W-1:0] b_eff;
  logic [W-1:0] cin_vec;

  always_comb begin
    b_eff   = sub_i ? ~b_i : b_i;
    cin_vec = {{(W-1){1'b0}}, sub_i};
    sum_o   = a_i + b_eff + cin_vec;
  end

  always_comb begin
    if (sub_i) begin
      AST_SUB_INVERTS: assert ((sum_o + b_i) == a_i) else $error("sub result does not invert add"); // R5
    end else begin
      AST_ADD_INVERTS: assert ((sum_o - b_i) == a_i) else $error("add result does not invert sub"); // R4
    end
  end
endmodule

// File: rtl/alu32_bitwise.sv
module alu32_bitwise #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] and_o,
  output logic [W-1:0] or_o,
  output logic [W-1:0] xor_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign and_o[i] = a_i[i] & b_i[i];
    assign or_o[i]  = a_i[i] | b_i[i];
    assign xor_o[i] = a_i[i] ^ b_i[i];
  end

  always_comb begin
    AST_XOR_PARTITION: assert ((and_o | xor_o) == or_o) else $error("bitwise outputs inconsistent"); // R3
    AST_AND_DISJOINT: assert ((and_o & xor_o) == '0) else $error("and/xor overlap"); // R1
  end
endmodule

// File: rtl/alu32_shift1.sv
module alu32_shift1 #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  output logic [W-1:0] shl_o,
  output logic [W-1:0] shr_o
);
  assign shl_o = {a_i[W-2:0], 1'b0};
  assign shr_o = {1'b0, a_i[W-1:1]};

  always_comb begin
    AST_SHL_FILL: assert (shl_o[0] == 1'b0) else $error("left shift lsb not zero"); // R6
    AST_SHR_FILL: assert (shr_o[W-1] == 1'b0) else $error("right shift msb not zero"); // R7
    AST_SHL_ROUNDTRIP: assert ((shl_o >> 1) == {1'b0, a_i[W-2:0]}) else $error("left shift lost bits"); // R6
  end
endmodule

// File: rtl/alu32_zero_det.sv
module alu32_zero_det #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  assign zero_o = ~(|val_i);
endmodule

// File: rtl/alu32_core.sv
module alu32_core
  import alu32_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [2:0]       op_sel,
  output logic [WIDTH-1:0] res_c,
  output logic             res_zero
);
  alu_op_e      op;
  logic [WIDTH-1:0] arith_r, and_r, or_r, xor_r, shl_r, shr_r;
  logic             is_sub;

  assign op     = alu_op_e'(op_sel);
  assign is_sub = (op == OP_SUB);

  alu32_addsub #(.W(WIDTH)) addsub_i (
    .a_i(op_a), .b_i(op_b), .sub_i(is_sub), .sum_o(arith_r)
  );

  alu32_bitwise #(.W(WIDTH)) bitwise_i (
    .a_i(op_a), .b_i(op_b), .and_o(and_r), .or_o(or_r), .xor_o(xor_r)
  );

  alu32_shift1 #(.W(WIDTH)) shift_i (
    .a_i(op_a), .shl_o(shl_r), .shr_o(shr_r)
  );

  always_comb begin
    case (op)
      OP_AND:  res_c = and_r;
      OP_OR:   res_c = or_r;
      OP_ADD:  res_c = arith_r;
      OP_XOR:  res_c = xor_r;
      OP_SUB:  res_c = arith_r;
      OP_SLL:  res_c = shl_r;
      OP_SRL:  res_c = shr_r;
      default: res_c = '0;
    endcase
  end

  alu32_zero_det #(.W(WIDTH)) zero_i (
    .val_i(res_c), .zero_o(res_zero)
  );

  always_comb begin
    AST_ZERO_MATCH: assert (res_zero == (res_c == '0)) else $error("zero flag mismatch"); // R9
    if (op == OP_RSV) begin
      AST_RSV_CLEAR: assert (res_zero && res_c == '0) else $error("unused code not cleared"); // R8
    end
    if (op == OP_SUB && op_a == op_b) begin
      AST_SUB_EQUAL_ZERO: assert (res_zero) else $error("equal operands not zero"); // R5
    end
  end
endmodule

// File: tb/alu32_core_tb_top.sv
module alu32_core_tb_top;
  logic        clk = 1'b0;
  logic [31:0] op_a, op_b, res_c;
  logic [2:0]  op_sel;
  logic        res_zero;
  int          n_checks = 0;
  int          n_errors = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  alu32_core dut_i (
    .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
    .res_c(res_c), .res_zero(res_zero)
  );

  function automatic logic [31:0] model(input logic [2:0] s, input logic [31:0] a, input logic [31:0] b);
    case (s)
      3'b000: return a & b;
      3'b001: return a | b;
      3'b010: return 32'((64'(a) + 64'(b)) % 64'h1_0000_0000);
      3'b011: return a ^ b;
      3'b110: return 32'((64'h1_0000_0000 + 64'(a) - 64'(b)) % 64'h1_0000_0000);
      3'b101: return 32'((64'(a) * 2) % 64'h1_0000_0000);
      3'b111: return a / 2;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag(input logic [2:0] s);
    case (s)
      3'b000: return "R1";
      3'b001: return "R2";
      3'b011: return "R3";
      3'b010: return "R4";
      3'b110: return "R5";
      3'b101: return "R6";
      3'b111: return "R7";
      default: return "R8";
    endcase
  endfunction

  // apply after a rising edge, sample at the next falling edge (same cycle, R10)
  task automatic run(input logic [2:0] s, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] exp_c;
    @(posedge clk);
    #1;
    op_sel = s; op_a = a; op_b = b;
    exp_c = model(s, a, b);
    @(negedge clk);
    n_checks++;
    if (res_c !== exp_c) begin
      n_errors++;
      $display("FAIL %s/R10 code=%b a=%h b=%h res_c actual=%h expected=%h", tag(s), s, a, b, res_c, exp_c);
    end
    n_checks++;
    if (res_zero !== (exp_c == 32'd0)) begin
      n_errors++;
      $display("FAIL R9 code=%b a=%h b=%h res_zero actual=%b expected=%b", s, a, b, res_zero, (exp_c == 32'd0));
    end
  endtask

  initial begin
    logic [31:0] corners [8];
    logic [31:0] sh_first;
    corners = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h8000_0000,
                32'h7FFF_FFFF, 32'hAAAA_5555, 32'h0000_FFFF, 32'h1234_5678};
    op_a = '0; op_b = '0; op_sel = '0;
    // all codes against all corner pairs (R1..R9)
    for (int s = 0; s < 8; s++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          run(3'(s), corners[i], corners[j]);
    // R4 wrap of carry out, R5 equal operands and borrow wrap
    run(3'b010, 32'hFFFF_FFFF, 32'h1);
    run(3'b110, 32'hDEAD_BEEF, 32'hDEAD_BEEF);
    run(3'b110, 32'h0, 32'h1);
    // R8 unused code ignores non-zero operands
    run(3'b100, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    // R6/R7: op_b has no effect on shifts
    for (int k = 0; k < 2; k++) begin
      logic [2:0] sc;
      sc = (k == 0) ? 3'b101 : 3'b111;
      run(sc, 32'hC3A5_0F81, 32'h0);
      sh_first = res_c;
      run(sc, 32'hC3A5_0F81, 32'hFFFF_FFFF);
      n_checks++;
      if (res_c !== sh_first) begin
        n_errors++;
        $display("FAIL %s op_b changed shift: actual=%h expected=%h", tag(sc), res_c, sh_first);
      end
    end
    // random sweep of every code
    for (int s = 0; s < 8; s++)
      for (int r = 0; r < 1500; r++)
        run(3'(s), $urandom, $urandom);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired: actual=hung expected=done");
      end
    join_any
    $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule